// File: doc/BRIEF.md
# Asynchronous Descriptor Rescan Scheduler

This block decides which control or bulk transfer descriptor gets the next bus transaction within one USB frame. Each of `NUM_SLOTS` slots holds an active flag, a remaining byte count and a per-slot packet time. At the start of every frame the scheduler walks the slots once in ascending order. It issues a transaction for each active slot that fits in the time left in the frame. It then keeps circling the slots round-robin, so a descriptor that still has data can get several transactions in the same frame until the frame budget is used up.

Only one transaction is outstanding at any time. The downstream packet engine receives the slot number and the remaining byte count. When it finishes, it returns the number of bytes moved and an error flag. The scheduler subtracts the bytes from the slot's count. It retires the slot when the count reaches zero or when an error is reported. An optional interrupt flag is raised when the ordered first pass of a frame finishes, and it stays set until it is cleared.

Top module: `async_rescan_sched`

## Requirements
- R1: After reset, `req_valid` and `async_irq` are 0 and every slot is inactive, so no request appears even when plenty of frame time is available.
- R2: A load sets the slot's remaining count and packet time. The slot becomes active only if the loaded byte count is nonzero. A load with a zero count never produces a request.
- R3: After a start-of-frame pulse, slots are examined one per idle cycle in ascending order from slot 0. Active slots that fit the budget are issued in that order.
- R4: On completion, the slot's remaining count drops by `done_bytes`, saturating at zero. The next request for that slot carries the reduced count on `req_bytes`.
- R5: A slot becomes inactive when its count reaches zero or when a completion reports `done_err` = 1. After that it receives no further request until it is reloaded.
- R6: After the first pass, the scan continues round-robin from the slot after the last one examined, wrapping past slot `NUM_SLOTS`-1 to 0. One slot may therefore be served several times in a frame.
- R7: A request is issued only when `time_left` >= `guard_time` + the slot's packet time. The sum is computed without overflow.
- R8: `req_valid` stays high, with `req_slot` and `req_bytes` unchanged, until the cycle in which `done_valid` is 1. It is low in the cycle after that, so at most one transaction is outstanding.
- R9: `async_irq` becomes 1 one cycle after the first pass of a frame finishes, but only if `irq_en` is 1. It stays 1 until `irq_clr` is pulsed. If a set and a clear occur in the same cycle, the set wins.
- R10: A `sof` pulse restarts the first pass at slot 0. No request is issued in the `sof` cycle.
- R11: A load aimed at the slot that has the outstanding transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse |
| ld_valid | input | 1 | Descriptor load strobe |
| ld_slot | input | SLOT_W | Slot being loaded |
| ld_bytes | input | CNT_W | Total bytes of the transfer |
| ld_pkt_time | input | TIME_W | Bus time one packet of this slot needs |
| time_left | input | TIME_W | Time remaining in the current frame |
| guard_time | input | TIME_W | Programmable safety margin |
| irq_en | input | 1 | Enables the first-pass-done flag |
| irq_clr | input | 1 | Clears the flag |
| req_valid | output | 1 | Transaction request outstanding |
| req_slot | output | SLOT_W | Slot of the request |
| req_bytes | output | CNT_W | Remaining byte count of that slot |
| done_valid | input | 1 | Transaction complete |
| done_bytes | input | CNT_W | Bytes moved by the transaction |
| done_err | input | 1 | Transaction ended in a fatal error |
| async_irq | output | 1 | First-pass-done flag |

## Verification
A corrupted active flag or count shows on the request port. It appears as a request for a retired slot, or as a wrong `req_bytes`, within one scan lap, which is at most `NUM_SLOTS` idle cycles. A wrong scan pointer or phase shows as an out-of-order slot in the first pass after `sof`, or as the interrupt flag rising at the wrong time. The budget comparison shows as a request that appears, or fails to appear, when `time_left` sits exactly one unit either side of the threshold.

// File: rtl/arsched_pkg.sv
package arsched_pkg;
  typedef enum logic {PH_FIRST = 1'b0, PH_RESCAN = 1'b1} phase_t;
endpackage

// File: rtl/arsched_slot_table.sv
module arsched_slot_table #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W = 16,
  parameter int TIME_W = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [SLOT_W-1:0] ld_slot,
  input  logic [CNT_W-1:0]  ld_bytes,
  input  logic [TIME_W-1:0] ld_pkt,
  input  logic              busy,
  input  logic [SLOT_W-1:0] busy_slot,
  input  logic              cmp_en,
  input  logic [CNT_W-1:0]  cmp_bytes,
  input  logic              cmp_err,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_active,
  output logic [CNT_W-1:0]  rd_count,
  output logic [TIME_W-1:0] rd_pkt
);
  logic              act [NUM_SLOTS];
  logic [CNT_W-1:0]  cnt [NUM_SLOTS];
  logic [TIME_W-1:0] pkt [NUM_SLOTS];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic hit_ld, hit_cmp, drain;
    // a load to the slot in flight is dropped; completion always targets that slot
    assign hit_ld  = ld_en && (ld_slot == SLOT_W'(i)) && !(busy && busy_slot == SLOT_W'(i));
    assign hit_cmp = cmp_en && (busy_slot == SLOT_W'(i));
    assign drain   = cmp_bytes >= cnt[i];

    always_ff @(posedge clk) begin
      if (rst)                            act[i] <= 1'b0;
      else if (hit_ld)                    act[i] <= (ld_bytes != '0);
      else if (hit_cmp && (cmp_err || drain)) act[i] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (hit_ld) begin
        cnt[i] <= ld_bytes;
        pkt[i] <= ld_pkt;
      end else if (hit_cmp) begin
        cnt[i] <= drain ? '0 : cnt[i] - cmp_bytes;
      end
    end
  end

  assign rd_active = act[rd_slot];
  assign rd_count  = cnt[rd_slot];
  assign rd_pkt    = pkt[rd_slot];
endmodule

// File: rtl/arsched_budget.sv
module arsched_budget #(
  parameter int TIME_W = 16
) (
  input  logic [TIME_W-1:0] time_left,
  input  logic [TIME_W-1:0] guard_time,
  input  logic [TIME_W-1:0] pkt_time,
  output logic              fits
);
  logic [TIME_W:0] need;
  assign need = {1'b0, guard_time} + {1'b0, pkt_time};
  assign fits = {1'b0, time_left} >= need;
endmodule

// File: rtl/arsched_scan.sv
module arsched_scan
  import arsched_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              cand_active,
  input  logic              cand_fits,
  input  logic [CNT_W-1:0]  cand_count,
  input  logic              done_valid,
  output logic [SLOT_W-1:0] ptr,
  output logic              req_valid,
  output logic [SLOT_W-1:0] req_slot,
  output logic [CNT_W-1:0]  req_bytes,
  output logic              pass_end
);
  phase_t phase;
  logic   idle;

  assign idle     = !req_valid && !sof;
  assign pass_end = idle && (phase == PH_FIRST) && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      phase     <= PH_FIRST;
      req_valid <= 1'b0;
      req_slot  <= '0;
      req_bytes <= '0;
    end else begin
      if (req_valid && done_valid) req_valid <= 1'b0;
      if (sof) begin
        ptr   <= '0;
        phase <= PH_FIRST;
      end else if (!req_valid) begin
        if (cand_active && cand_fits) begin
          req_valid <= 1'b1;
          req_slot  <= ptr;
          req_bytes <= cand_count;
        end
        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        if (pass_end) phase <= PH_RESCAN;
      end
    end
  end
endmodule

// File: rtl/arsched_irq.sv
module arsched_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic enable,
  input  logic clear,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                     flag <= 1'b0;
    else if (set_evt && enable)  flag <= 1'b1;
    else if (clear)              flag <= 1'b0;
  end
endmodule

// File: rtl/async_rescan_sched.sv
module async_rescan_sched #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W = 16,
  parameter int TIME_W = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              ld_valid,
  input  logic [SLOT_W-1:0] ld_slot,
  input  logic [CNT_W-1:0]  ld_bytes,
  input  logic [TIME_W-1:0] ld_pkt_time,
  input  logic [TIME_W-1:0] time_left,
  input  logic [TIME_W-1:0] guard_time,
  input  logic              irq_en,
  input  logic              irq_clr,
  output logic              req_valid,
  output logic [SLOT_W-1:0] req_slot,
  output logic [CNT_W-1:0]  req_bytes,
  input  logic              done_valid,
  input  logic [CNT_W-1:0]  done_bytes,
  input  logic              done_err,
  output logic              async_irq
);
  logic [SLOT_W-1:0] ptr;
  logic              cand_active, cand_fits, pass_end;
  logic [CNT_W-1:0]  cand_count;
  logic [TIME_W-1:0] cand_pkt;

  arsched_slot_table #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_table (
    .clk(clk), .rst(rst),
    .ld_en(ld_valid), .ld_slot(ld_slot), .ld_bytes(ld_bytes), .ld_pkt(ld_pkt_time),
    .busy(req_valid), .busy_slot(req_slot),
    .cmp_en(req_valid && done_valid), .cmp_bytes(done_bytes), .cmp_err(done_err),
    .rd_slot(ptr), .rd_active(cand_active), .rd_count(cand_count), .rd_pkt(cand_pkt)
  );

  arsched_budget #(.TIME_W(TIME_W)) u_budget (
    .time_left(time_left), .guard_time(guard_time), .pkt_time(cand_pkt), .fits(cand_fits)
  );

  arsched_scan #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst(rst), .sof(sof),
    .cand_active(cand_active), .cand_fits(cand_fits), .cand_count(cand_count),
    .done_valid(done_valid), .ptr(ptr),
    .req_valid(req_valid), .req_slot(req_slot), .req_bytes(req_bytes), .pass_end(pass_end)
  );

  arsched_irq u_irq (
    .clk(clk), .rst(rst), .set_evt(pass_end), .enable(irq_en), .clear(irq_clr), .flag(async_irq)
  );
endmodule

// File: rtl/arsched_chk.sv
module arsched_chk #(
  parameter int SLOT_W = 3,
  parameter int CNT_W = 16,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sof,
  input logic [TIME_W-1:0] time_left,
  input logic [TIME_W-1:0] guard_time,
  input logic              irq_en,
  input logic              irq_clr,
  input logic              req_valid,
  input logic [SLOT_W-1:0] req_slot,
  input logic [CNT_W-1:0]  req_bytes,
  input logic              done_valid,
  input logic              async_irq
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !done_valid |=> req_valid && $stable(req_slot) && $stable(req_bytes));
  // R8
  one_out_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && done_valid |=> !req_valid);
  // R7
  budget_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> $past(time_left) >= $past(guard_time));
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    async_irq && !irq_clr |=> async_irq);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(async_irq) |-> $past(irq_en));
  // R10
  sof_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sof && !req_valid |=> !req_valid);
endmodule

bind async_rescan_sched arsched_chk #(.SLOT_W(SLOT_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst(rst), .sof(sof), .time_left(time_left), .guard_time(guard_time),
  .irq_en(irq_en), .irq_clr(irq_clr), .req_valid(req_valid), .req_slot(req_slot),
  .req_bytes(req_bytes), .done_valid(done_valid), .async_irq(async_irq)
);

// File: tb/async_rescan_sched_test.sv
module async_rescan_sched_test;
  localparam int SW = 3, CW = 16, TW = 16;

  logic clk = 1'b0, rst = 1'b1, sof = 1'b0;
  logic ld_valid = 1'b0;
  logic [SW-1:0] ld_slot = '0;
  logic [CW-1:0] ld_bytes = '0;
  logic [TW-1:0] ld_pkt_time = '0, time_left = '0, guard_time = 16'd10;
  logic irq_en = 1'b0, irq_clr = 1'b0;
  logic req_valid, async_irq;
  logic [SW-1:0] req_slot;
  logic [CW-1:0] req_bytes;
  logic done_valid = 1'b0, done_err = 1'b0;
  logic [CW-1:0] done_bytes = '0;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  async_rescan_sched uut (.*);

  // {slot, expected req_bytes, bytes moved, error}
  localparam int VEC [5][4] = '{
    '{1, 100, 40, 0}, '{3, 30, 30, 0}, '{5, 20, 8, 1}, '{1, 60, 40, 0}, '{1, 20, 25, 0}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic load(input int s, input int b, input int p);
    ld_valid = 1'b1; ld_slot = SW'(s); ld_bytes = CW'(b); ld_pkt_time = TW'(p);
    tick();
    ld_valid = 1'b0;
  endtask

  task automatic wait_req(input string tag);
    int n = 0;
    while (!req_valid && n < 40) begin tick(); n++; end
    check(req_valid, tag, int'(req_valid), 1);
  endtask

  task automatic finish_req(input int db, input int err);
    done_valid = 1'b1; done_bytes = CW'(db); done_err = err[0];
    tick();
    done_valid = 1'b0; done_err = 1'b0;
    check(!req_valid, "R8 drop after done", int'(req_valid), 0);
  endtask

  task automatic expect_idle(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin tick(); if (req_valid) seen = 1; end
    check(!seen, tag, int'(seen), 0);
  endtask

  task automatic serve(input int s, input int b, input int db, input int err, input string tag);
    logic [SW-1:0] s0;
    wait_req(tag);
    check(req_slot == SW'(s), {tag, " slot"}, int'(req_slot), s);
    check(req_bytes == CW'(b), {tag, " bytes"}, int'(req_bytes), b);
    s0 = req_slot;
    tick();
    check(req_valid && req_slot == s0, "R8 hold", int'(req_valid), 1);
    finish_req(db, err);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) tick();
    check(!req_valid && !async_irq, "R1 reset outputs", int'(req_valid), 0);
    rst = 1'b0;
    time_left = 16'd1000;
    expect_idle(20, "R1 all slots inactive");
    time_left = 16'd0;
    // R2: slot 6 loaded with zero bytes stays inactive
    load(1, 100, 5); load(3, 30, 5); load(6, 0, 5); load(5, 20, 5);
    tick();
    sof = 1'b1; time_left = 16'd1000; irq_en = 1'b1;
    tick();
    sof = 1'b0;
    // R3 ordered first pass, R4 decrements, R5 retire, R6 rescan
    for (int v = 0; v < 5; v++)
      serve(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], $sformatf("R3 R4 R6 vec%0d", v));
    expect_idle(20, "R5 R2 retired or empty slots silent");
    check(async_irq, "R9 flag after first pass", int'(async_irq), 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    check(!async_irq, "R9 flag cleared", int'(async_irq), 0);
    // R7: 14 < 10 + 5
    time_left = 16'd14;
    load(2, 50, 5);
    expect_idle(20, "R7 budget one short");
    time_left = 16'd15;
    wait_req("R7 budget exact");
    check(req_slot == 3'd2 && req_bytes == 16'd50, "R7 slot2 issued", int'(req_slot), 2);
    // R11: reload of in-flight slot is dropped
    load(2, 999, 5);
    finish_req(50, 0);
    expect_idle(20, "R11 in-flight load ignored");
    // R10: restart from slot 0, flag disabled this frame
    time_left = 16'd0; irq_en = 1'b0;
    load(7, 10, 5); load(0, 10, 5);
    repeat (5) tick();
    sof = 1'b1; time_left = 16'd1000;
    tick();
    sof = 1'b0;
    serve(0, 10, 10, 0, "R10 restart slot0");
    serve(7, 10, 10, 0, "R10 then slot7");
    expect_idle(12, "R10 nothing left");
    check(!async_irq, "R9 disabled flag stays low", int'(async_irq), 0);
    summary();
  end
endmodule